// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the finite-state control unit of a small processor with one accumulator. It tracks which phase of the instruction cycle the machine is in with a two-bit cycle code: instruction fetch, operand-address indirection, opcode execution, or interrupt entry. It also keeps a time-step counter that selects the register transfer to run inside that phase. Every clock cycle it combines the cycle code and time step with the opcode held in the instruction register, the indirect bit of the word being fetched, a pending-interrupt request and a zero flag from the memory buffer. From these it drives one strobe per register transfer.

The surrounding datapath holds PC, MAR, MBR, IR, the accumulator and memory. On each rising edge it performs whatever transfers are strobed. The unit never touches data. It only decides which transfers happen in which cycle. The two fixed addresses used by interrupt entry are parameters, and they are brought out so the datapath can load them.

Top module: `cu_hardwired_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the cycle code to fetch (`cyc_o` = 00) and the time step to T1 (`step_o` = 0, where T1..T4 are shown as 0..3). In that state the only strobe asserted is `mar_from_pc_o`.
- R2: The cycle codes are 00 fetch, 01 indirect, 10 execute and 11 interrupt. Fetch, indirect and interrupt each last three steps. After indirect comes execute, and after interrupt comes fetch. An instruction with no indirection and no interrupt therefore takes 3 cycles of fetch plus its execute length.
- R3: Fetch runs as follows. T1 loads MAR from PC. T2 reads memory into MBR and increments PC, both in that same step. T3 copies MBR into IR.
- R4: At the end of fetch the next cycle is indirect when `mbr_ind_i` is high during T3, and execute otherwise. Indirect runs as follows. T1 loads MAR from the IR address field. T2 reads memory into MBR. T3 copies the MBR address field into the IR address field.
- R5: At the last execute step the unit samples `irq_i`. If it is high, interrupt follows; otherwise fetch follows. Interrupt runs as follows. T1 copies PC into MBR. T2 loads MAR with `SAVE_ADDR` and PC with `ISR_ADDR`. T3 writes MBR to memory.
- R6: Opcodes are 3 bits: LDA=000, ADD=001, AND=010, ISZ=011, BSA=100. For LDA, ADD and AND, execute runs as follows. T1 loads MAR from the IR address. T2 reads memory into MBR. T3 then sets the accumulator to MBR, to accumulator+MBR, or to accumulator AND MBR, respectively.
- R7: ISZ takes four execute steps. T1 loads MAR from the IR address. T2 reads memory into MBR. T3 increments MBR. T4 writes MBR to memory and, only when `mbr_zero_i` is high, also increments PC, so the next instruction is skipped.
- R8: BSA takes three execute steps. T1 loads MAR from the IR address and loads MBR from PC. T2 loads PC from the IR address and writes MBR to memory. T3 increments PC, so execution resumes at target+1.
- R9: Opcodes 101, 110 and 111 finish execute in a single step with no strobe asserted.
- R10: The memory-read strobe `mbr_from_mem_o` is high exactly in T2 of fetch, in T2 of indirect, and in T2 of execute for LDA, ADD, AND or ISZ. It is never high together with `mem_wr_o`.
- R11: In any step, each destination register (MAR, MBR, PC, accumulator) has at most one source strobe. No register is written by one transfer while another transfer reads it.
- R12: Whenever the cycle code changes, the time step returns to T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_op_i | input | 3 | Opcode field of IR |
| mbr_ind_i | input | 1 | Indirect bit of the word in MBR |
| mbr_zero_i | input | 1 | MBR equals zero |
| irq_i | input | 1 | Enabled interrupt pending |
| cyc_o | output | 2 | Current cycle code |
| step_o | output | 2 | Current time step (0 = T1) |
| mar_from_pc_o | output | 1 | MAR <- PC |
| mar_from_ir_o | output | 1 | MAR <- IR address field |
| mar_from_save_o | output | 1 | MAR <- save address |
| mbr_from_mem_o | output | 1 | Memory read into MBR |
| mbr_from_pc_o | output | 1 | MBR <- PC |
| mbr_inc_o | output | 1 | MBR <- MBR + 1 |
| ir_from_mbr_o | output | 1 | IR <- MBR |
| ir_addr_from_mbr_o | output | 1 | IR address field <- MBR address field |
| pc_inc_o | output | 1 | PC <- PC + 1 |
| pc_from_ir_o | output | 1 | PC <- IR address field |
| pc_from_isr_o | output | 1 | PC <- service-routine address |
| acc_from_mbr_o | output | 1 | Accumulator <- MBR |
| acc_add_o | output | 1 | Accumulator <- accumulator + MBR |
| acc_and_o | output | 1 | Accumulator <- accumulator AND MBR |
| mem_wr_o | output | 1 | Memory at MAR <- MBR |
| save_addr_o | output | ADDR_W | Fixed return-address save location |
| isr_addr_o | output | ADDR_W | Fixed service-routine start address |

## Verification
A wrong cycle code or step count does not stay hidden inside the unit. Within the same instruction it moves a strobe into the wrong cycle. By the next instruction boundary this shows up as a PC, accumulator or memory word that differs from an instruction-level model, or as an instruction taking the wrong number of cycles. A mis-decoded opcode or a bad skip decision changes the architectural state within one instruction. A missed or misrouted interrupt leaves the save location and PC different after the three-cycle entry. The memory-read strobe and the silence during undefined opcodes are also checked cycle by cycle, so a slot error is reported in the cycle where it occurs.

// File: rtl/cu_pkg.sv
package cu_pkg;

    localparam int OP_W     = 3;
    localparam int STEP_W   = 2;
    localparam int N_STEPS  = 1 << STEP_W;

    // execute lengths in steps
    localparam int LEN_PHASE = 3;
    localparam int LEN_ISZ   = 4;
    localparam int LEN_IDLE  = 1;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_IND   = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INT   = 2'b11
    } cyc_e;

    localparam logic [OP_W-1:0] OP_LDA = 3'b000;
    localparam logic [OP_W-1:0] OP_ADD = 3'b001;
    localparam logic [OP_W-1:0] OP_AND = 3'b010;
    localparam logic [OP_W-1:0] OP_ISZ = 3'b011;
    localparam logic [OP_W-1:0] OP_BSA = 3'b100;

    typedef struct packed {
        logic lda;
        logic add;
        logic land;
        logic isz;
        logic bsa;
        logic rd;      // opcode reads its operand from memory
    } opdec_t;

    typedef struct packed {
        cyc_e              cyc;
        logic [STEP_W-1:0] step;
    } seq_t;

    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mar_save;
        logic mbr_mem;
        logic mbr_pc;
        logic mbr_inc;
        logic ir_mbr;
        logic ira_mbr;
        logic pc_inc;
        logic pc_ir;
        logic pc_isr;
        logic acc_ld;
        logic acc_add;
        logic acc_and;
        logic mem_wr;
    } strobe_t;

endpackage

// File: rtl/cu_op_decode.sv
module cu_op_decode
    import cu_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    output opdec_t            dec_o,
    output logic [STEP_W-1:0] exec_last_o
);

    localparam logic [STEP_W-1:0] LAST_PHASE = STEP_W'(LEN_PHASE - 1);
    localparam logic [STEP_W-1:0] LAST_ISZ   = STEP_W'(LEN_ISZ - 1);
    localparam logic [STEP_W-1:0] LAST_IDLE  = STEP_W'(LEN_IDLE - 1);

    always_comb begin
        dec_o       = '0;
        exec_last_o = LAST_IDLE;
        case (op_i)
            OP_LDA: begin dec_o.lda  = 1'b1; exec_last_o = LAST_PHASE; end
            OP_ADD: begin dec_o.add  = 1'b1; exec_last_o = LAST_PHASE; end
            OP_AND: begin dec_o.land = 1'b1; exec_last_o = LAST_PHASE; end
            OP_ISZ: begin dec_o.isz  = 1'b1; exec_last_o = LAST_ISZ;   end
            OP_BSA: begin dec_o.bsa  = 1'b1; exec_last_o = LAST_PHASE; end
            default: ;
        endcase
        dec_o.rd = dec_o.lda | dec_o.add | dec_o.land | dec_o.isz;
    end

endmodule

// File: rtl/cu_seq.sv
module cu_seq
    import cu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] exec_last_i,
    input  logic              mbr_ind_i,
    input  logic              irq_i,
    output seq_t              seq_o
);

    localparam logic [STEP_W-1:0] LAST_FIXED = STEP_W'(LEN_PHASE - 1);

    seq_t seq_d, seq_q;
    logic at_last;

    always_comb begin
        seq_d   = seq_q;
        at_last = (seq_q.cyc == CYC_EXEC) ? (seq_q.step == exec_last_i)
                                          : (seq_q.step == LAST_FIXED);
        if (at_last) begin
            seq_d.step = '0;
            case (seq_q.cyc)
                CYC_FETCH: seq_d.cyc = mbr_ind_i ? CYC_IND : CYC_EXEC;
                CYC_IND:   seq_d.cyc = CYC_EXEC;
                CYC_EXEC:  seq_d.cyc = irq_i ? CYC_INT : CYC_FETCH;
                CYC_INT:   seq_d.cyc = CYC_FETCH;
                default:   seq_d.cyc = CYC_FETCH;
            endcase
        end else begin
            seq_d.step = seq_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.cyc  <= CYC_FETCH;
            seq_q.step <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seq_o = seq_q;

endmodule

// File: rtl/cu_strobe_gen.sv
module cu_strobe_gen
    import cu_pkg::*;
(
    input  seq_t    seq_i,
    input  opdec_t  dec_i,
    input  logic    mbr_zero_i,
    output strobe_t stb_o
);

    logic [N_STEPS-1:0] t;

    // one-hot time-step lines
    for (genvar k = 0; k < N_STEPS; k++) begin : g_tdec
        assign t[k] = (seq_i.step == STEP_W'(k));
    end

    always_comb begin
        stb_o = '0;
        case (seq_i.cyc)
            CYC_FETCH: begin
                stb_o.mar_pc  = t[0];
                stb_o.mbr_mem = t[1];
                stb_o.pc_inc  = t[1];
                stb_o.ir_mbr  = t[2];
            end
            CYC_IND: begin
                stb_o.mar_ir  = t[0];
                stb_o.mbr_mem = t[1];
                stb_o.ira_mbr = t[2];
            end
            CYC_INT: begin
                stb_o.mbr_pc   = t[0];
                stb_o.mar_save = t[1];
                stb_o.pc_isr   = t[1];
                stb_o.mem_wr   = t[2];
            end
            CYC_EXEC: begin
                stb_o.mar_ir  = t[0] & (dec_i.rd | dec_i.bsa);
                stb_o.mbr_pc  = t[0] & dec_i.bsa;
                stb_o.mbr_mem = t[1] & dec_i.rd;
                stb_o.pc_ir   = t[1] & dec_i.bsa;
                stb_o.acc_ld  = t[2] & dec_i.lda;
                stb_o.acc_add = t[2] & dec_i.add;
                stb_o.acc_and = t[2] & dec_i.land;
                stb_o.mbr_inc = t[2] & dec_i.isz;
                stb_o.mem_wr  = (t[1] & dec_i.bsa) | (t[3] & dec_i.isz);
                stb_o.pc_inc  = (t[2] & dec_i.bsa) | (t[3] & dec_i.isz & mbr_zero_i);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cu_hardwired_ctrl.sv
module cu_hardwired_ctrl
    import cu_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 8'hF0,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = 8'h60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ir_op_i,
    input  logic              mbr_ind_i,
    input  logic              mbr_zero_i,
    input  logic              irq_i,
    output logic [1:0]        cyc_o,
    output logic [1:0]        step_o,
    output logic              mar_from_pc_o,
    output logic              mar_from_ir_o,
    output logic              mar_from_save_o,
    output logic              mbr_from_mem_o,
    output logic              mbr_from_pc_o,
    output logic              mbr_inc_o,
    output logic              ir_from_mbr_o,
    output logic              ir_addr_from_mbr_o,
    output logic              pc_inc_o,
    output logic              pc_from_ir_o,
    output logic              pc_from_isr_o,
    output logic              acc_from_mbr_o,
    output logic              acc_add_o,
    output logic              acc_and_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] save_addr_o,
    output logic [ADDR_W-1:0] isr_addr_o
);

    opdec_t            dec;
    logic [STEP_W-1:0] exec_last;
    seq_t              seq;
    strobe_t           stb;

    cu_op_decode u_dec (
        .op_i        (ir_op_i),
        .dec_o       (dec),
        .exec_last_o (exec_last)
    );

    cu_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .exec_last_i (exec_last),
        .mbr_ind_i   (mbr_ind_i),
        .irq_i       (irq_i),
        .seq_o       (seq)
    );

    cu_strobe_gen u_stb (
        .seq_i      (seq),
        .dec_i      (dec),
        .mbr_zero_i (mbr_zero_i),
        .stb_o      (stb)
    );

    assign cyc_o              = seq.cyc;
    assign step_o             = seq.step;
    assign mar_from_pc_o      = stb.mar_pc;
    assign mar_from_ir_o      = stb.mar_ir;
    assign mar_from_save_o    = stb.mar_save;
    assign mbr_from_mem_o     = stb.mbr_mem;
    assign mbr_from_pc_o      = stb.mbr_pc;
    assign mbr_inc_o          = stb.mbr_inc;
    assign ir_from_mbr_o      = stb.ir_mbr;
    assign ir_addr_from_mbr_o = stb.ira_mbr;
    assign pc_inc_o           = stb.pc_inc;
    assign pc_from_ir_o       = stb.pc_ir;
    assign pc_from_isr_o      = stb.pc_isr;
    assign acc_from_mbr_o     = stb.acc_ld;
    assign acc_add_o          = stb.acc_add;
    assign acc_and_o          = stb.acc_and;
    assign mem_wr_o           = stb.mem_wr;
    assign save_addr_o        = SAVE_ADDR;
    assign isr_addr_o         = ISR_ADDR;

endmodule

// File: rtl/cu_hardwired_ctrl_chk.sv
module cu_hardwired_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op,
    input logic       mbr_ind,
    input logic       irq,
    input logic [1:0] cyc,
    input logic [1:0] step,
    input logic       mar_pc,
    input logic       mar_ir,
    input logic       mar_save,
    input logic       mbr_mem,
    input logic       mbr_pc,
    input logic       mbr_inc,
    input logic       ir_mbr,
    input logic       ira_mbr,
    input logic       pc_inc,
    input logic       pc_ir,
    input logic       pc_isr,
    input logic       acc_ld,
    input logic       acc_add,
    input logic       acc_and,
    input logic       mem_wr
);

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cyc == 2'b00 && step == 2'b00));

    // R12
    step_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc != $past(cyc)) |-> (step == 2'b00));

    // R4
    fetch_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'b00 && step == 2'd2) |=>
        (cyc == ($past(mbr_ind) ? 2'b01 : 2'b10)));

    // R5
    int_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'b11 && step == 2'b00) |-> ($past(cyc) == 2'b10 && $past(irq)));

    // R2
    int_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'b11 && step == 2'd2) |=> (cyc == 2'b00));

    // R9
    idle_op_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'b10 && op >= 3'b101) |->
        ($countones({mar_pc, mar_ir, mar_save, mbr_mem, mbr_pc, mbr_inc, ir_mbr, ira_mbr,
                     pc_inc, pc_ir, pc_isr, acc_ld, acc_add, acc_and, mem_wr}) == 0));

    // R10
    mem_rd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        mbr_mem |-> (step == 2'd1 && !mem_wr));

    // R11
    mar_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mar_pc, mar_ir, mar_save}));

    // R11
    pc_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_inc, pc_ir, pc_isr}));

    // R11
    acc_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_ld, acc_add, acc_and}));

    // R11
    mbr_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (mbr_mem | mbr_pc | mbr_inc) |-> !(ir_mbr | ira_mbr | acc_ld | acc_add | acc_and | mem_wr));

    // R11
    pc_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_inc | pc_ir | pc_isr) |-> !(mar_pc | mbr_pc));

endmodule

bind cu_hardwired_ctrl cu_hardwired_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op       (ir_op_i),
    .mbr_ind  (mbr_ind_i),
    .irq      (irq_i),
    .cyc      (cyc_o),
    .step     (step_o),
    .mar_pc   (mar_from_pc_o),
    .mar_ir   (mar_from_ir_o),
    .mar_save (mar_from_save_o),
    .mbr_mem  (mbr_from_mem_o),
    .mbr_pc   (mbr_from_pc_o),
    .mbr_inc  (mbr_inc_o),
    .ir_mbr   (ir_from_mbr_o),
    .ira_mbr  (ir_addr_from_mbr_o),
    .pc_inc   (pc_inc_o),
    .pc_ir    (pc_from_ir_o),
    .pc_isr   (pc_from_isr_o),
    .acc_ld   (acc_from_mbr_o),
    .acc_add  (acc_add_o),
    .acc_and  (acc_and_o),
    .mem_wr   (mem_wr_o)
);

// File: tb/tb_cu_hardwired_ctrl.sv
module tb_cu_hardwired_ctrl;

    localparam int AW = 8;
    localparam int DW = 12;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] SAVE = 8'hF0;
    localparam logic [AW-1:0] ISR  = 8'h60;
    localparam int N_INSTR = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0;
    always #10 clk = ~clk;

    // bench datapath
    logic [DW-1:0] imem [DEPTH];
    logic [DW-1:0] dmem [DEPTH];
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] mbr, ir, r1;

    // instruction-level model
    logic [DW-1:0] mmem [DEPTH];
    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_r1;
    int            m_cyc;

    logic [1:0]    cyc, step;
    logic mar_pc, mar_ir, mar_save, mbr_mem, mbr_pc, mbr_inc, ir_mbr, ira_mbr;
    logic pc_inc, pc_ir, pc_isr, acc_ld, acc_add, acc_and, mem_wr;
    logic [AW-1:0] save_addr, isr_addr;

    cu_hardwired_ctrl #(.ADDR_W(AW), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) dut (
        .clk(clk), .rst(rst), .ir_op_i(ir[11:9]), .mbr_ind_i(mbr[8]),
        .mbr_zero_i(mbr == '0), .irq_i(irq), .cyc_o(cyc), .step_o(step),
        .mar_from_pc_o(mar_pc), .mar_from_ir_o(mar_ir), .mar_from_save_o(mar_save),
        .mbr_from_mem_o(mbr_mem), .mbr_from_pc_o(mbr_pc), .mbr_inc_o(mbr_inc),
        .ir_from_mbr_o(ir_mbr), .ir_addr_from_mbr_o(ira_mbr), .pc_inc_o(pc_inc),
        .pc_from_ir_o(pc_ir), .pc_from_isr_o(pc_isr), .acc_from_mbr_o(acc_ld),
        .acc_add_o(acc_add), .acc_and_o(acc_and), .mem_wr_o(mem_wr),
        .save_addr_o(save_addr), .isr_addr_o(isr_addr)
    );

    always @(posedge clk) begin
        if (rst) begin
            dmem <= imem;
            pc <= '0; mar <= '0; mbr <= '0; ir <= '0; r1 <= '0;
        end else begin
            if (mar_pc)        mar <= pc;
            else if (mar_ir)   mar <= ir[AW-1:0];
            else if (mar_save) mar <= save_addr;
            if (mbr_mem)       mbr <= dmem[mar];
            else if (mbr_pc)   mbr <= DW'(pc);
            else if (mbr_inc)  mbr <= mbr + 1'b1;
            if (ir_mbr)        ir <= mbr;
            else if (ira_mbr)  ir[AW-1:0] <= mbr[AW-1:0];
            if (pc_inc)        pc <= pc + 1'b1;
            else if (pc_ir)    pc <= ir[AW-1:0];
            else if (pc_isr)   pc <= isr_addr;
            if (acc_ld)        r1 <= mbr;
            else if (acc_add)  r1 <= r1 + mbr;
            else if (acc_and)  r1 <= r1 & mbr;
            if (mem_wr)        dmem[mar] <= mbr;
        end
    end

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one instruction (plus optional interrupt entry) on the model
    task automatic model_step(input bit take_irq);
        logic [DW-1:0] w, v;
        logic [AW-1:0] a;
        w = mmem[m_pc];
        m_pc = m_pc + 1'b1;
        a = w[AW-1:0];
        m_cyc = 3;
        if (w[8]) begin
            a = mmem[a][AW-1:0];
            m_cyc += 3;
        end
        case (w[11:9])
            3'b000: begin m_r1 = mmem[a];        m_cyc += 3; end
            3'b001: begin m_r1 = m_r1 + mmem[a]; m_cyc += 3; end
            3'b010: begin m_r1 = m_r1 & mmem[a]; m_cyc += 3; end
            3'b011: begin
                v = mmem[a] + 1'b1;
                mmem[a] = v;
                if (v == '0) m_pc = m_pc + 1'b1;
                m_cyc += 4;
            end
            3'b100: begin
                mmem[a] = DW'(m_pc);
                m_pc = a + 1'b1;
                m_cyc += 3;
            end
            default: m_cyc += 1;
        endcase
        if (take_irq) begin
            mmem[SAVE] = DW'(m_pc);
            m_pc = ISR;
            m_cyc += 3;
        end
    endtask

    function automatic bit exp_rd(input logic [1:0] c, input logic [1:0] s, input logic [2:0] op);
        return (s == 2'd1) && (c == 2'b00 || c == 2'b01 || (c == 2'b10 && op <= 3'b011));
    endfunction

    task automatic per_cycle();
        chk(mbr_mem == exp_rd(cyc, step, ir[11:9]), "R10", "memory read strobe",
            mbr_mem, exp_rd(cyc, step, ir[11:9]));
        if (cyc == 2'b10 && ir[11:9] >= 3'b101)
            chk({mar_pc, mar_ir, mar_save, mbr_mem, mbr_pc, mbr_inc, ir_mbr, ira_mbr,
                 pc_inc, pc_ir, pc_isr, acc_ld, acc_add, acc_and, mem_wr} == '0,
                "R9", "idle opcode strobes",
                {mar_pc, mar_ir, mar_save, mbr_mem, mbr_pc, mbr_inc, ir_mbr, ira_mbr,
                 pc_inc, pc_ir, pc_isr, acc_ld, acc_add, acc_and, mem_wr}, 0);
    endtask

    task automatic compare_state();
        int bad_a;
        bad_a = -1;
        chk(pc == m_pc, "R3/R5/R7/R8", "PC at boundary", pc, m_pc);
        chk(r1 == m_r1, "R6", "accumulator at boundary", r1, m_r1);
        for (int a = 0; a < DEPTH; a++)
            if (bad_a < 0 && dmem[a] !== mmem[a]) bad_a = a;
        chk(bad_a < 0, "R4/R5/R7/R8", "memory image", bad_a, -1);
    endtask

    initial begin
        int unsigned seed;
        int cnt;
        bit tk;
        seed = $urandom(32'd4711);
        for (int a = 0; a < DEPTH; a++) imem[a] = DW'($urandom);
        // directed program
        imem[8'h00] = 12'h040;  // LDA 40
        imem[8'h01] = 12'h241;  // ADD 41
        imem[8'h02] = 12'h442;  // AND 42  (interrupt after it)
        imem[ISR]   = 12'h603;  // ISZ 03 at service routine: FFF -> 0, skip
        imem[8'h03] = 12'hFFF;
        imem[8'h62] = 12'h144;  // LDA indirect via 44
        imem[8'h44] = 12'h040;
        imem[8'h63] = 12'h850;  // BSA 50
        imem[8'h51] = 12'h645;  // ISZ 45, 5 -> 6 no skip
        imem[8'h45] = 12'h005;
        imem[8'h52] = 12'hE00;  // undefined opcode
        imem[8'h40] = 12'h3A5;
        imem[8'h41] = 12'h11C;
        imem[8'h42] = 12'h0F7;
        mmem = imem;
        m_pc = '0;
        m_r1 = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cyc == 2'b00 && step == 2'b00, "R1", "cycle/step in reset", {cyc, step}, 0);
        chk(mar_pc == 1'b1 && pc_inc == 1'b0 && mbr_mem == 1'b0, "R1",
            "strobes in reset", {mar_pc, pc_inc, mbr_mem}, 3'b100);
        rst = 1'b0;

        for (int i = 0; i < N_INSTR; i++) begin
            compare_state();
            tk  = (i == 2) || ($urandom % 8 == 0);
            irq = tk;
            model_step(tk);
            cnt = 0;
            do begin
                per_cycle();
                @(negedge clk);
                cnt++;
                if (cyc == 2'b11) irq = 1'b0;
            end while (!(cyc == 2'b00 && step == 2'b00) && cnt < 64);
            chk(cnt == m_cyc, "R2 R12", "cycles per instruction", cnt, m_cyc);
        end
        compare_state();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule